// File: doc/BRIEF.md
# Bit scatter/gather engine

The engine performs one of two bit-permutation operations on a pair of operands, a source word and a mask. In scatter mode the low-order bits of the source are placed, in ascending order, at the bit positions where the mask holds a one. In gather mode the source bits found at the mask's one positions are packed, in ascending order, into the low-order bits of the result. A single op input selects the mode when a job is started.

The engine is iterative. Each clock it locates the lowest remaining one in the mask with a trailing-zero search. It moves one bit between source and result. It then removes that mask bit by ANDing the mask with itself minus one. The run time therefore follows the number of ones in the mask rather than the word width. A one-cycle start pulse launches a job. A one-cycle done pulse marks its end, and the result stays on the output until the next job is accepted. The word width is a parameter and may be 32 or 64.

Top module: `bitfield_scatter_gather`

## Requirements
- R1: With op = 0 (scatter), the n-th lowest set bit of the mask (n counted from 0) receives source bit n in the result.
- R2: With op = 1 (gather), result bit n holds the source bit located at the n-th lowest set bit of the mask.
- R3: Every result bit that the walk does not write is zero. In scatter mode these are the bits outside the mask. In gather mode these are the bits at or above the mask's popcount.
- R4: A start seen high at a clock edge while busy is low is accepted, and busy is high after that edge. With P ones in the mask, done is high after the (P+1)-th edge following the accepting edge, and busy falls at that same edge.
- R5: A job with an all-zero mask raises done after the first edge following acceptance, with a zero result.
- R6: Done is high for exactly one cycle per job, and busy is low whenever done is high.
- R7: While idle with start low, the result does not change, whatever the source, mask and op inputs do.
- R8: A start that arrives while busy is high is ignored. The running job finishes with the operands it was started with.
- R9: The result reads zero in the cycle after a job is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a job; sampled only while idle |
| op | input | 1 | 0 = scatter, 1 = gather |
| src | input | WIDTH | Source word |
| mask | input | WIDTH | Selection mask |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse at the end of a job |
| result | output | WIDTH | Result of the last job, held while idle |

## Verification
The bench builds the engine with WIDTH = 64. At that width the top bit 63 is reachable, so a mask bit at the far end of the trailing-zero search can be exercised. The same width gives an all-ones mask, the worst case of 65 walk cycles, and long gather outputs whose upper bits must stay zero. A behavioural model predicts busy, done and the final result for every cycle. Directed jobs cover the empty mask, the full mask, single-bit masks at both ends and a start issued mid-walk, and a batch of random jobs in both modes follows.

// File: rtl/bitfield_scatter_gather.sv
module bitfield_scatter_gather #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             op,
  input  logic [WIDTH-1:0] src,
  input  logic [WIDTH-1:0] mask,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result
);
  localparam int IW = $clog2(WIDTH);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] src_q, mask_q, res_q;
  logic [IW-1:0]    k_q, low_pos;
  logic             op_q, busy_q, done_q;

  always_comb begin
    low_pos = '0;
    for (int i = WIDTH - 1; i >= 0; i--)
      if (mask_q[i]) low_pos = IW'(i);
  end

  wire [WIDTH-1:0] mask_next = mask_q & (mask_q - ONE);
  wire             accept    = start && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      mask_q <= '0;
      res_q  <= '0;
      k_q    <= '0;
      op_q   <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        src_q  <= src;
        mask_q <= mask;
        op_q   <= op;
        k_q    <= '0;
        res_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (mask_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          if (op_q) res_q[k_q]     <= src_q[low_pos];
          else      res_q[low_pos] <= src_q[k_q];
          mask_q <= mask_next;
          k_q    <= k_q + 1'b1;
        end
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = res_q;
endmodule

// File: rtl/bitfield_scatter_gather_chk.sv
module bitfield_scatter_gather_chk #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [WIDTH-1:0] mask,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] result
);
  p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  p_fall_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_zero_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && mask == '0 |=> busy ##1 (done && result == '0));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(result));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> result == '0);
endmodule

bind bitfield_scatter_gather bitfield_scatter_gather_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mask(mask),
  .busy(busy), .done(done), .result(result)
);

// File: tb/sim_bitfield_scatter_gather.sv
module sim_bitfield_scatter_gather;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         op = 1'b0;
  logic [W-1:0] src = '0, mask = '0;
  logic         busy, done;
  logic [W-1:0] result;

  int tests = 0, fails = 0, cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bitfield_scatter_gather #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .src(src), .mask(mask),
    .busy(busy), .done(done), .result(result)
  );

  function automatic logic [W-1:0] ref_calc(logic o, logic [W-1:0] s, logic [W-1:0] m);
    logic [W-1:0] r = '0;
    int n = 0;
    for (int i = 0; i < W; i++)
      if (m[i]) begin
        if (o) r[n] = s[i];
        else   r[i] = s[n];
        n++;
      end
    return r;
  endfunction

  function automatic int pop(logic [W-1:0] m);
    int c = 0;
    for (int i = 0; i < W; i++) c += int'(m[i]);
    return c;
  endfunction

  logic         m_busy = 0, m_done = 0, m_op = 0;
  logic [W-1:0] m_res = '0, m_final = '0;
  int           m_left = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_res <= '0; m_left <= 0;
    end else begin
      m_done <= 0;
      if (start && !m_busy) begin
        m_busy  <= 1;
        m_op    <= op;
        m_final <= ref_calc(op, src, mask);
        m_left  <= pop(mask);
        m_res   <= '0;
      end else if (m_busy) begin
        if (m_left == 0) begin
          m_busy <= 0; m_done <= 1; m_res <= m_final;
        end else m_left <= m_left - 1;
      end
    end
  end

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(busy == m_busy, "R4 busy", W'(busy), W'(m_busy));
      check(done == m_done, "R6 done", W'(done), W'(m_done));
      if (!m_busy)
        check(result == m_res, m_op ? "R2 result" : "R1 result", result, m_res);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !finished) begin
      finished = 1;
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(logic o, logic [W-1:0] s, logic [W-1:0] m, string req);
    logic [W-1:0] exp = ref_calc(o, s, m);
    @(negedge clk);
    start = 1; op = o; src = s; mask = m;
    @(negedge clk);
    start = 0;
    check(result == '0, "R9 cleared", result, '0);
    while (!done) @(negedge clk);
    check(result == exp, req, result, exp);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && result == '0, "R4 reset", result, '0);
    rst_n = 1;

    run(0, 64'h0000_0000_0000_00A5, 64'hF0F0_0000_0000_0F0F, "R1 scatter");
    run(1, 64'h1234_5678_9ABC_DEF0, 64'hFF00_FF00_00FF_00FF, "R2 gather");
    run(0, '1, 64'h8000_0400_0010_0001, "R3 scatter zeros");
    run(1, '1, 64'h0000_F000_0000_000F, "R3 gather zeros");
    run(0, 64'h1, 64'h8000_0000_0000_0000, "R1 top bit");
    run(1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R2 top bit");
    run(0, 64'hDEAD_BEEF_0BAD_F00D, '1, "R1 full mask");
    run(1, 64'hDEAD_BEEF_0BAD_F00D, '1, "R2 full mask");

    // R5: empty mask finishes after the first edge following acceptance
    @(negedge clk);
    start = 1; op = 0; src = '1; mask = '0;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    check(done && result == '0, "R5 empty mask", result, '0);
    @(negedge clk);

    // R8: a second start during the walk is ignored
    @(negedge clk);
    start = 1; op = 1; src = 64'h0F0F; mask = 64'hFF;
    @(negedge clk);
    start = 1; op = 0; src = '1; mask = '1;
    @(negedge clk);
    start = 0;
    wait_done();
    check(result == 64'h0F, "R8 ignored start", result, 64'h0F);

    // R7: idle input changes leave the result alone
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      op = i[0]; src = {$urandom, $urandom}; mask = {$urandom, $urandom};
    end
    @(negedge clk);
    check(result == 64'h0F, "R7 hold", result, 64'h0F);

    for (int i = 0; i < 40; i++)
      run(i[0], {$urandom, $urandom}, {$urandom, $urandom}, i[0] ? "R2 random" : "R1 random");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule